// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Feedback Divider

This block divides a fast oscillator-derived clock by a programmable integer for the feedback path of an integer-N phase-locked loop. It is built from three parts:

- an 8/9 dual-modulus prescaler, made of a synchronous 4/5 core and a divide-by-2 stage that follows it;
- a main period counter holding a count P;
- a swallow count S, which holds the prescaler in its divide-by-9 mode for the first S prescaler periods of every output cycle.

The overall ratio is therefore 9·S + 8·(P−S) = 8·P + S input cycles per feedback pulse. A separate programmable divider on the reference clock produces the comparison pulse that goes to the phase detector.

The ratios arrive as plain parallel inputs. The block samples them only at the boundary of its own output cycle, so software may write them at any time without ever producing a short or long runt interval. Illegal settings are clamped: a zero P or R acts as 1, and an S larger than P acts as P.

The block has no data stream, so it has no valid/ready interface and no back-pressure rules. Every port is a plain control or pulse pin.

Top module: `psdiv_feedback`

## Requirements
- R1: With effective counts P and S in force, consecutive rising edges of `fb_pulse` are exactly 8·P + S `clk_in` cycles apart.
- R2: `fb_pulse` is high for exactly one `clk_in` cycle per output cycle.
- R3: Within an output cycle, the prescaler periods marked by `pre_pulse` are 9 cycles long for the first S of them and 8 cycles long for the remaining P−S, so P prescaler periods make up each output cycle.
- R4: The prescaler modulus select is active-low. Low selects divide-by-9, meaning the 4/5 core counts 5 in the second half. High selects divide-by-8.
- R5: P = 0 is treated as P = 1, and S > P is treated as S = P. For example, P=0 and S=5 gives a ratio of 9, and P=3 and S=7 gives a ratio of 27.
- R6: P and S values written in the middle of an output cycle do not alter that cycle. They take effect from the next one.
- R7: `ref_pulse` is high for one `ref_clk` cycle in every R cycles. R = 0 is treated as 1, and R = 1 gives a pulse in every cycle.
- R8: An R value written in the middle of a reference interval takes effect only after the current interval ends.
- R9: While `rst_n` is low, all outputs are low. After release, the first `fb_pulse` is sampled high after the (8·P+S+1)-th `clk_in` rising edge, and the first `ref_pulse` after the R-th `ref_clk` rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast divided-oscillator clock |
| ref_clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| div_p | input | P_W | Main counter value P |
| div_s | input | S_W | Swallow count S |
| div_r | input | R_W | Reference division ratio R |
| fb_pulse | output | 1 | One-cycle feedback pulse per output cycle |
| pre_pulse | output | 1 | One-cycle pulse at the end of each prescaler period |
| ref_pulse | output | 1 | Divided reference pulse |

## Verification
The embedded properties assume that `rst_n` is released away from the active edge of either clock, and that the ratio inputs change only away from that edge. The bench drives every input on a falling edge of `clk_in` and releases reset at a time that no `ref_clk` rising edge shares. The properties do not assume legal ratio values. Instead, they check the clamped values held inside the block, so the sweep deliberately includes P = 0, S > P and R = 0. Every ratio change is made mid-cycle, which exercises the boundary-only loading.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;
  // Width of the synchronous core in its short mode; the prescaler is twice this.
  localparam int unsigned CORE_BASE = 4;
  localparam int unsigned PRE_LOW   = 2 * CORE_BASE;

  // Modulus select, active-low for the long (swallow) mode.
  typedef enum logic {
    MOD_NINE  = 1'b0,
    MOD_EIGHT = 1'b1
  } mod_sel_e;
endpackage

// File: rtl/psdiv_core45.sv
module psdiv_core45 #(
  parameter int unsigned BASE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext,
  output logic core_tc
);
  localparam int unsigned CW = $clog2(BASE + 1);
  localparam logic [CW-1:0] LAST_S = CW'(BASE - 1);
  localparam logic [CW-1:0] LAST_L = CW'(BASE);

  logic [CW-1:0] cnt;

  // Terminal count: BASE-1 normally, BASE when the extended mode is active.
  assign core_tc = run && (cnt == (ext ? LAST_L : LAST_S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (core_tc) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R4
  core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_L);
endmodule

// File: rtl/psdiv_prescaler.sv
module psdiv_prescaler
  import psdiv_pkg::*;
#(
  parameter int unsigned BASE = CORE_BASE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  input  logic mode_n,
  output logic pre_tick
);
  localparam int unsigned PCW = $clog2(2 * BASE + 2);

  logic     half;
  logic     ext;
  logic     core_tc;
  mod_sel_e mode_q;

  // The extra count is inserted only in the second half when divide-by-9 is selected.
  assign ext      = half && (mode_q == MOD_NINE);
  assign pre_tick = core_tc && half;

  psdiv_core45 #(.BASE(BASE)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .ext     (ext),
    .core_tc (core_tc)
  );

  // Divide-by-2 stage: advances once per core period, as a ripple stage would.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half   <= 1'b0;
      mode_q <= MOD_EIGHT;
    end else begin
      if (!run)         half <= 1'b0;
      else if (core_tc) half <= ~half;
      if (load)         mode_q <= mod_sel_e'(mode_n);
    end
  end

  // Period checker: cycles elapsed within the current prescaler period.
  logic [PCW-1:0] pcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (!run)     pcnt <= '0;
    else if (pre_tick) pcnt <= '0;
    else               pcnt <= pcnt + 1'b1;
  end

  // R4
  presc_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> (pcnt == ((mode_q == MOD_NINE) ? PCW'(2 * BASE) : PCW'(2 * BASE - 1))));
endmodule

// File: rtl/psdiv_swallow_ctl.sv
module psdiv_swallow_ctl #(
  parameter int unsigned P_W = 8,
  parameter int unsigned S_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] p_in,
  input  logic [S_W-1:0] s_in,
  input  logic           pre_tick,
  output logic           run,
  output logic           load,
  output logic           mode_n,
  output logic           fb_pulse
);
  logic           run_q;
  logic [P_W-1:0] p_q, s_q, k, k_nxt;
  logic [P_W-1:0] p_eff, s_ext, s_eff;
  logic           prime, last, wrap;

  // Clamp the written values to a legal pair.
  assign p_eff = (p_in == '0) ? P_W'(1) : p_in;
  assign s_ext = P_W'(s_in);
  assign s_eff = (s_ext > p_eff) ? p_eff : s_ext;

  assign prime = !run_q;
  assign last  = (k == p_q - 1'b1);
  assign wrap  = run_q && pre_tick && last;
  assign k_nxt = k + 1'b1;

  // Mode for the period that starts at the coming edge (low = swallow).
  assign mode_n = (prime || wrap) ? (s_eff == '0) : !(k_nxt < s_q);
  assign load   = prime || pre_tick;
  assign run    = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      p_q      <= P_W'(1);
      s_q      <= '0;
      k        <= '0;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= wrap;
      if (prime) begin
        run_q <= 1'b1;
        p_q   <= p_eff;
        s_q   <= s_eff;
        k     <= '0;
      end else if (pre_tick) begin
        if (last) begin
          k   <= '0;
          p_q <= p_eff;
          s_q <= s_eff;
        end else begin
          k <= k_nxt;
        end
      end
    end
  end

  // R2
  fb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R5
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((p_q != '0) && (s_q <= p_q)));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap) |=> ($stable(p_q) && $stable(s_q)));

  // R3
  period_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (k < p_q));
endmodule

// File: rtl/psdiv_ref_div.sv
module psdiv_ref_div #(
  parameter int unsigned R_W = 8
) (
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] r_in,
  output logic           ref_pulse
);
  logic           run;
  logic [R_W-1:0] r_q, rcnt, r_eff;

  assign r_eff     = (r_in == '0) ? R_W'(1) : r_in;
  assign ref_pulse = run && (rcnt == r_q - 1'b1);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      r_q  <= R_W'(1);
      rcnt <= '0;
    end else if (!run) begin
      run  <= 1'b1;
      r_q  <= r_eff;
      rcnt <= '0;
    end else if (ref_pulse) begin
      rcnt <= '0;
      r_q  <= r_eff;
    end else begin
      rcnt <= rcnt + 1'b1;
    end
  end

  // R7
  ref_width_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> (!ref_pulse || r_q == R_W'(1)));

  // R7
  ref_nonzero_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    run |-> (r_q != '0));

  // R8
  ref_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (run && !ref_pulse) |=> $stable(r_q));
endmodule

// File: rtl/psdiv_feedback.sv
module psdiv_feedback
  import psdiv_pkg::*;
#(
  parameter int unsigned P_W = 8,
  parameter int unsigned S_W = 4,
  parameter int unsigned R_W = 8
) (
  input  logic           clk_in,
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] div_p,
  input  logic [S_W-1:0] div_s,
  input  logic [R_W-1:0] div_r,
  output logic           fb_pulse,
  output logic           pre_pulse,
  output logic           ref_pulse
);
  logic run, load, mode_n, pre_tick;

  psdiv_prescaler #(.BASE(CORE_BASE)) u_presc (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .run      (run),
    .load     (load),
    .mode_n   (mode_n),
    .pre_tick (pre_tick)
  );

  psdiv_swallow_ctl #(.P_W(P_W), .S_W(S_W)) u_ctl (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .p_in     (div_p),
    .s_in     (div_s),
    .pre_tick (pre_tick),
    .run      (run),
    .load     (load),
    .mode_n   (mode_n),
    .fb_pulse (fb_pulse)
  );

  psdiv_ref_div #(.R_W(R_W)) u_ref (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .r_in      (div_r),
    .ref_pulse (ref_pulse)
  );

  assign pre_pulse = pre_tick;

  // R9
  reset_quiet_chk: assert property (@(posedge clk_in)
    !rst_n |-> (!fb_pulse && !pre_pulse));
endmodule

// File: tb/psdiv_feedback_tb.sv
module psdiv_feedback_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 16;

  logic       clk_in = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div_p = 8'd3, div_r = 8'd4;
  logic [3:0] div_s = 4'd2;
  logic       fb_pulse, pre_pulse, ref_pulse;
  int         total = 0, bad = 0, cyc = 0, rcyc = 0;

  always #(CLK_PERIOD/2) clk_in = ~clk_in;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;
  always @(posedge clk_in) cyc++;
  always @(posedge ref_clk) rcyc++;

  psdiv_feedback u_dut (
    .clk_in(clk_in), .ref_clk(ref_clk), .rst_n(rst_n),
    .div_p(div_p), .div_s(div_s), .div_r(div_r),
    .fb_pulse(fb_pulse), .pre_pulse(pre_pulse), .ref_pulse(ref_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_p(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int eff_s(input int p, input int s);
    return (s > eff_p(p)) ? eff_p(p) : s;
  endfunction

  // Skip to the next cycle boundary, then measure one full output cycle.
  task automatic fb_cycle(input int p, input int s);
    int pe, se, m, w, prev, len;
    pe = eff_p(p);
    se = eff_s(p, s);
    m  = 8 * pe + se;
    do @(negedge clk_in); while (!fb_pulse);
    w    = cyc;
    prev = w - 1;
    @(negedge clk_in);
    check(!fb_pulse, "R2 width", int'(fb_pulse), 0);
    for (int j = 0; j < pe; j++) begin
      while (!pre_pulse) @(negedge clk_in);
      len = cyc - prev;
      check(len == ((j < se) ? 9 : 8), (p == 0 || s > p) ? "R3/R5 period" : "R3 period",
            len, (j < se) ? 9 : 8);
      prev = cyc;
      @(negedge clk_in);
    end
    while (!fb_pulse) @(negedge clk_in);
    check(cyc - w == m, (p == 0 || s > p) ? "R1/R5 ratio" : "R1 ratio", cyc - w, m);
  endtask

  // Count reference pulses over four intervals after a boundary.
  task automatic ref_window(input int r);
    int re, hits;
    re    = (r == 0) ? 1 : r;
    div_r = 8'(r);
    do @(negedge ref_clk); while (!ref_pulse);
    hits = 0;
    for (int i = 0; i < 4 * re; i++) begin
      @(negedge ref_clk);
      if (ref_pulse) hits++;
    end
    check(hits == 4 && ref_pulse, "R7 ref count", hits, 4);
  endtask

  initial begin
    int n, c0, rc0, w;
    // R9: outputs quiet during reset
    repeat (4) @(negedge clk_in);
    check(!fb_pulse && !pre_pulse && !ref_pulse, "R9 reset quiet",
          int'({fb_pulse, pre_pulse, ref_pulse}), 0);
    rst_n = 1'b1;
    c0  = cyc;
    rc0 = rcyc;
    fork
      begin
        do @(negedge clk_in); while (!fb_pulse);
        n = cyc - c0;
        check(n == 27, "R9 first fb", n, 27);
      end
      begin
        int rn;
        do @(negedge ref_clk); while (!ref_pulse);
        rn = rcyc - rc0;
        check(rn == 4, "R9 first ref", rn, 4);
      end
    join

    // R1 R3 R5: near-exhaustive sweep, changes written mid-cycle
    for (int p = 0; p <= 6; p++) begin
      for (int s = 0; s <= 9; s++) begin
        div_p = 8'(p);
        div_s = 4'(s);
        fb_cycle(p, s);
      end
    end

    // R6: change in the middle of a cycle applies one cycle later
    div_p = 8'd4; div_s = 4'd1;
    fb_cycle(4, 1);
    repeat (5) @(negedge clk_in);
    div_p = 8'd2; div_s = 4'd2;
    w = cyc - 5;
    do @(negedge clk_in); while (!fb_pulse);
    check(cyc - w == 33, "R6 old ratio kept", cyc - w, 33);
    w = cyc;
    do @(negedge clk_in); while (!fb_pulse);
    check(cyc - w == 18, "R6 new ratio", cyc - w, 18);

    // R7: reference ratios including the clamped zero
    for (int r = 0; r <= 6; r++) ref_window(r);
    ref_window(9);

    // R8: mid-interval change of R
    ref_window(5);
    w = rcyc;
    repeat (2) @(negedge ref_clk);
    div_r = 8'd3;
    do @(negedge ref_clk); while (!ref_pulse);
    check(rcyc - w == 5, "R8 old R kept", rcyc - w, 5);
    w = rcyc;
    do @(negedge ref_clk); while (!ref_pulse);
    check(rcyc - w == 3, "R8 new R", rcyc - w, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule